// File: doc/BRIEF.md
# Bus Listener Acceptor Handshake with Holdoff

This block is the receiving half of the three-wire byte handshake on an IEEE 488 instrument bus. The block works as a listener. It announces that it is ready by releasing NRFD while it holds NDAC asserted. It captures the byte on the data lines when the talker asserts DAV, and it asserts NRFD at once so that no second byte can start. After a fixed number of clock cycles it releases NDAC to acknowledge the byte. When DAV drops, it asserts NDAC again.

The captured byte stays in a data-in register, and the block raises a byte-in interrupt, a DMA request, or both, depending on configuration. NRFD is released only after the host reads that register. A holdoff can be set for every byte or only for bytes that end a transfer. While a holdoff is set, NRFD stays asserted until the host gives an explicit release, even after the read. An end flag is stored with each byte. It is set by EOI or by a match against a programmable end-of-string character or the newline code, and the match can use 7 or 8 bits. When ATN is asserted, the block moves to the not-ready state, with both NRFD and NDAC asserted.

All bus signals on the ports are active high, with 1 meaning asserted. The inputs are assumed to be already synchronised to `clk`.

Top module: `gpib_acceptor`

## Requirements
- R1: After reset, NRFD and NDAC are both released (0). The data register and end flag are 0, and the interrupt, DMA request and holdoff outputs are 0.
- R2: The block is ready when listening is enabled, ATN is false, no unread byte is pending and no holdoff is set. In that state it shows NRFD = 0 and NDAC = 1 from the cycle after the edge that saw the enable.
- R3: If DAV is sampled true in the ready state, then after that edge NRFD = 1, NDAC = 1, `data_o` holds the sampled `dio_i`, and a byte is pending. `data_o` changes at no other time.
- R4: NDAC is released exactly ACK_CYCLES cycles after NRFD was asserted for a captured byte. NRFD stays asserted while NDAC is released.
- R5: If DAV is sampled false while the byte is acknowledged, NDAC is asserted again after that edge. NRFD stays asserted while the byte is unread or a holdoff is set.
- R6: `byte_int_o` equals (byte pending AND `int_en_i`), and `dma_req_o` equals (byte pending AND `dma_en_i`). Both fall after the edge that samples `rd_strobe_i`.
- R7: A read strobe sampled while a byte is pending, with no holdoff and the handshake idle, releases NRFD after that edge. A read strobe with no byte pending has no effect on NRFD, NDAC or `data_o`.
- R8: A holdoff is set at capture when `hold_all_i` is 1, or when `hold_end_i` is 1 and the byte's end flag is 1. NRFD then stays asserted after the read until `release_i` is sampled. `holdoff_o` shows the holdoff.
- R9: While ATN is sampled true, the following cycle shows NRFD = 1 and NDAC = 1, and DAV is ignored. A byte that was already captured is kept.
- R10: At capture, the end flag is set if EOI is true, or if `eos_en_i` is 1 and the byte matches `eos_char_i`, or if `nl_en_i` is 1 and the byte matches 0x0A. The matches compare bits 6:0 when `eos_8bit_i` = 0 and all 8 bits when it is 1.
- R11: With listening disabled and ATN false, NRFD and NDAC are both released after the next edge, and DAV is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| listen_en_i | input | 1 | Listener addressed and active |
| atn_i | input | 1 | Bus attention, asserted high |
| dav_i | input | 1 | Data valid from talker, asserted high |
| eoi_i | input | 1 | End-or-identify with the byte |
| dio_i | input | DW | Bus data byte, true polarity |
| rd_strobe_i | input | 1 | One-cycle read of the data-in register |
| release_i | input | 1 | Clears a holdoff |
| hold_all_i | input | 1 | Hold off after every byte |
| hold_end_i | input | 1 | Hold off after a byte whose end flag is set |
| eos_en_i | input | 1 | Enable end-of-string compare |
| eos_8bit_i | input | 1 | 1: compare 8 bits, 0: compare 7 bits |
| eos_char_i | input | DW | End-of-string character |
| nl_en_i | input | 1 | Enable newline (0x0A) compare |
| int_en_i | input | 1 | Byte-in interrupt enable |
| dma_en_i | input | 1 | DMA input enable |
| nrfd_o | output | 1 | Not ready for data, asserted high |
| ndac_o | output | 1 | Not data accepted, asserted high |
| data_o | output | DW | Data-in register |
| end_o | output | 1 | End flag of the stored byte |
| byte_int_o | output | 1 | Byte-in interrupt |
| dma_req_o | output | 1 | DMA request |
| holdoff_o | output | 1 | Holdoff in force |

## Verification
The assertions assume that the talker keeps the byte handshake well formed. DAV is raised only after NRFD is seen released, and it is kept high until NDAC is seen released. The assertions also assume that `dio_i` is steady whenever DAV is high. They treat `rd_strobe_i` and `release_i` as single-cycle pulses. The stimulus respects these rules: it asserts DAV only when the block is ready or when ATN or a disabled listener makes DAV ignored, it waits for NDAC release before dropping DAV, and it drives every pulse for exactly one cycle.

// File: rtl/gpib_acceptor.sv
module gpib_acceptor #(
  parameter int DW = 8,
  parameter int ACK_CYCLES = 3,
  parameter logic [DW-1:0] NL_CODE = 8'h0A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          listen_en_i,
  input  logic          atn_i,
  input  logic          dav_i,
  input  logic          eoi_i,
  input  logic [DW-1:0] dio_i,
  input  logic          rd_strobe_i,
  input  logic          release_i,
  input  logic          hold_all_i,
  input  logic          hold_end_i,
  input  logic          eos_en_i,
  input  logic          eos_8bit_i,
  input  logic [DW-1:0] eos_char_i,
  input  logic          nl_en_i,
  input  logic          int_en_i,
  input  logic          dma_en_i,
  output logic          nrfd_o,
  output logic          ndac_o,
  output logic [DW-1:0] data_o,
  output logic          end_o,
  output logic          byte_int_o,
  output logic          dma_req_o,
  output logic          holdoff_o
);

  localparam int CW = (ACK_CYCLES > 1) ? $clog2(ACK_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(ACK_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_NRDY, S_RDY, S_ACPT, S_ACK} state_t;

  state_t        state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          full_q, hold_q;

  logic eos_hit, nl_hit, end_now, accept, rdy_ok;

  assign eos_hit = eos_8bit_i ? (dio_i == eos_char_i)
                              : (dio_i[DW-2:0] == eos_char_i[DW-2:0]);
  assign nl_hit  = eos_8bit_i ? (dio_i == NL_CODE)
                              : (dio_i[DW-2:0] == NL_CODE[DW-2:0]);
  assign end_now = eoi_i | (eos_en_i & eos_hit) | (nl_en_i & nl_hit);

  assign accept = (state_q == S_RDY) && dav_i && listen_en_i && !atn_i;
  assign rdy_ok = listen_en_i && !atn_i && (!full_q || rd_strobe_i)
                  && (!hold_q || release_i);

  always_comb begin
    state_d = state_q;
    if (atn_i)             state_d = S_NRDY;
    else if (!listen_en_i) state_d = S_IDLE;
    else begin
      case (state_q)
        S_IDLE, S_NRDY: state_d = rdy_ok ? S_RDY : S_NRDY;
        S_RDY:          state_d = dav_i ? S_ACPT : S_RDY;
        S_ACPT:         state_d = (cnt_q == CNT_LAST) ? S_ACK : S_ACPT;
        S_ACK:          state_d = dav_i ? S_ACK : (rdy_ok ? S_RDY : S_NRDY);
        default:        state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      hold_q  <= 1'b0;
      data_o  <= '0;
      end_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q != S_ACPT || state_d != S_ACPT) cnt_q <= '0;
      else                                        cnt_q <= cnt_q + 1'b1;
      if (accept) begin
        data_o <= dio_i;
        end_o  <= end_now;
        full_q <= 1'b1;
        hold_q <= hold_all_i | (hold_end_i & end_now);
      end else begin
        if (rd_strobe_i) full_q <= 1'b0;
        if (release_i)   hold_q <= 1'b0;
      end
    end
  end

  assign nrfd_o     = (state_q == S_NRDY) || (state_q == S_ACPT) || (state_q == S_ACK);
  assign ndac_o     = (state_q == S_NRDY) || (state_q == S_RDY)  || (state_q == S_ACPT);
  assign byte_int_o = full_q & int_en_i;
  assign dma_req_o  = full_q & dma_en_i;
  assign holdoff_o  = hold_q;

endmodule

module gpib_acceptor_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          listen_en_i,
  input logic          atn_i,
  input logic          dav_i,
  input logic          rd_strobe_i,
  input logic          release_i,
  input logic          nrfd_o,
  input logic          ndac_o,
  input logic [DW-1:0] data_o,
  input logic          byte_int_o,
  input logic          dma_req_o,
  input logic          holdoff_o
);

  AST_CAPTURE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ndac_o && !nrfd_o && dav_i && listen_en_i) |=> (nrfd_o && ndac_o)); // R3

  AST_DATA_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ndac_o && !nrfd_o) |=> $stable(data_o)); // R3

  AST_ACK_KEEPS_NRFD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ndac_o) && $past(listen_en_i)) |-> nrfd_o); // R4

  AST_DAV_DROP_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ndac_o && nrfd_o && !dav_i && listen_en_i) |=> ndac_o); // R5

  AST_READ_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe_i && !(ndac_o && !nrfd_o && dav_i)) |=> (!byte_int_o && !dma_req_o)); // R6

  AST_HOLDOFF_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (holdoff_o && !release_i) |=> (nrfd_o || !ndac_o)); // R8

  AST_ATN_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    atn_i |=> (nrfd_o && ndac_o)); // R9

endmodule

bind gpib_acceptor gpib_acceptor_chk #(.DW(DW)) u_chk (.*);

// File: tb/gpib_acceptor_tb.sv
module gpib_acceptor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACKC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic listen_en_i = 0, atn_i = 0, dav_i = 0, eoi_i = 0;
  logic [7:0] dio_i = 8'h00, eos_char_i = 8'h00;
  logic rd_strobe_i = 0, release_i = 0, hold_all_i = 0, hold_end_i = 0;
  logic eos_en_i = 0, eos_8bit_i = 0, nl_en_i = 0, int_en_i = 0, dma_en_i = 0;
  logic nrfd_o, ndac_o, end_o, byte_int_o, dma_req_o, holdoff_o;
  logic [7:0] data_o;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  gpib_acceptor #(.DW(8), .ACK_CYCLES(ACKC)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: phase 0 idle, 1 not ready, 2 ready, 3 accepting, 4 acknowledged
  int m_ph = 0, m_wait = 0;
  bit m_pend = 0, m_hold = 0, m_end = 0;
  logic [7:0] m_data = 8'h00;

  function automatic bit m_match(logic [7:0] a, logic [7:0] b);
    return eos_8bit_i ? (a == b) : (a[6:0] == b[6:0]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_wait = 0; m_pend = 0; m_hold = 0; m_end = 0; m_data = 8'h00;
    end else begin
      bit may_ready;
      bit fresh;
      int nph;
      fresh = (m_ph == 2) && dav_i && listen_en_i && !atn_i;
      may_ready = listen_en_i && !atn_i && (!m_pend || rd_strobe_i) && (!m_hold || release_i);
      nph = m_ph;
      if (atn_i) nph = 1;
      else if (!listen_en_i) nph = 0;
      else if (m_ph <= 1) nph = may_ready ? 2 : 1;
      else if (m_ph == 2) nph = dav_i ? 3 : 2;
      else if (m_ph == 3) nph = (m_wait == 1) ? 4 : 3;
      else nph = dav_i ? 4 : (may_ready ? 2 : 1);
      if (nph == 3 && m_ph != 3) m_wait = ACKC;
      else if (nph == 3) m_wait = m_wait - 1;
      if (fresh) begin
        m_data = dio_i;
        m_end = eoi_i || (eos_en_i && m_match(dio_i, eos_char_i)) || (nl_en_i && m_match(dio_i, 8'h0A));
        m_pend = 1;
        m_hold = hold_all_i || (hold_end_i && m_end);
      end else begin
        if (rd_strobe_i) m_pend = 0;
        if (release_i) m_hold = 0;
      end
      m_ph = nph;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(cur_req, "nrfd", nrfd_o, (m_ph == 1 || m_ph == 3 || m_ph == 4));
      chk(cur_req, "ndac", ndac_o, (m_ph == 1 || m_ph == 2 || m_ph == 3));
      chk(cur_req, "data", data_o, m_data);
      chk(cur_req, "end", end_o, m_end);
      chk(cur_req, "int", byte_int_o, m_pend && int_en_i);
      chk(cur_req, "dma", dma_req_o, m_pend && dma_en_i);
      chk(cur_req, "holdoff", holdoff_o, m_hold);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic send(logic [7:0] b, logic e);
    dio_i = b; eoi_i = e; dav_i = 1;
    tick();
    chk("R3", "nrfd after DAV", nrfd_o, 1);
    chk("R3", "captured byte", data_o, b);
    tick(ACKC - 1);
    chk("R4", "ndac held", ndac_o, 1);
    tick();
    chk("R4", "ndac released", ndac_o, 0);
    chk("R4", "nrfd while acked", nrfd_o, 1);
    dav_i = 0; eoi_i = 0;
    tick();
    chk("R5", "ndac reasserted", ndac_o, 1);
    chk("R5", "nrfd still held", nrfd_o, 1);
  endtask

  task automatic read_byte();
    rd_strobe_i = 1; tick(); rd_strobe_i = 0;
  endtask

  initial begin
    tick(3);
    cur_req = "R1";
    chk("R1", "nrfd", nrfd_o, 0); chk("R1", "ndac", ndac_o, 0);
    chk("R1", "data", data_o, 0); chk("R1", "int", byte_int_o, 0);
    rst_n = 1;
    tick();
    chk("R1", "end", end_o, 0); chk("R1", "holdoff", holdoff_o, 0);

    cur_req = "R2";
    listen_en_i = 1; tick();
    chk("R2", "nrfd ready", nrfd_o, 0); chk("R2", "ndac ready", ndac_o, 1);

    cur_req = "R6";
    int_en_i = 1;
    send(8'h41, 0);
    chk("R6", "int raised", byte_int_o, 1); chk("R6", "dma idle", dma_req_o, 0);
    cur_req = "R7";
    read_byte();
    chk("R7", "nrfd released by read", nrfd_o, 0);
    chk("R6", "int cleared", byte_int_o, 0);

    cur_req = "R6";
    int_en_i = 0; dma_en_i = 1;
    send(8'h42, 0);
    chk("R6", "dma raised", dma_req_o, 1); chk("R6", "int off", byte_int_o, 0);
    read_byte();
    chk("R6", "dma cleared", dma_req_o, 0);
    dma_en_i = 0;

    cur_req = "R7";
    read_byte(); tick();
    chk("R7", "empty read nrfd", nrfd_o, 0);
    chk("R7", "empty read ndac", ndac_o, 1);
    chk("R7", "empty read data", data_o, 8'h42);

    cur_req = "R10";
    eos_en_i = 1; eos_char_i = 8'h8D; eos_8bit_i = 0;
    send(8'h0D, 0); chk("R10", "7-bit eos match", end_o, 1); read_byte();
    eos_8bit_i = 1;
    send(8'h0D, 0); chk("R10", "8-bit eos miss", end_o, 0); read_byte();
    send(8'h8D, 0); chk("R10", "8-bit eos match", end_o, 1); read_byte();
    eos_en_i = 0; nl_en_i = 1;
    send(8'h0A, 0); chk("R10", "newline match", end_o, 1); read_byte();
    nl_en_i = 0;
    send(8'h55, 1); chk("R10", "eoi end", end_o, 1); read_byte();
    send(8'h56, 0); chk("R10", "no end", end_o, 0); read_byte();

    cur_req = "R8";
    hold_end_i = 1;
    send(8'h57, 0); chk("R8", "no holdoff on plain byte", holdoff_o, 0); read_byte();
    chk("R8", "plain byte released", nrfd_o, 0);
    send(8'h66, 1); chk("R8", "holdoff on end", holdoff_o, 1);
    read_byte(); tick(3);
    chk("R8", "nrfd kept after read", nrfd_o, 1);
    release_i = 1; tick(); release_i = 0;
    chk("R8", "nrfd released", nrfd_o, 0); chk("R8", "holdoff cleared", holdoff_o, 0);
    hold_end_i = 0; hold_all_i = 1;
    send(8'h67, 0); chk("R8", "holdoff all", holdoff_o, 1);
    release_i = 1; tick(); release_i = 0;
    chk("R8", "released before read", nrfd_o, 1);
    read_byte(); chk("R8", "read after release", nrfd_o, 0);
    hold_all_i = 0;

    cur_req = "R9";
    atn_i = 1; tick();
    chk("R9", "atn nrfd", nrfd_o, 1); chk("R9", "atn ndac", ndac_o, 1);
    dio_i = 8'h99; dav_i = 1; tick(5);
    chk("R9", "dav ignored", data_o, 8'h67); chk("R9", "still not ready", ndac_o, 1);
    dav_i = 0; atn_i = 0; tick();
    chk("R9", "ready after atn", nrfd_o, 0);
    dio_i = 8'h33; dav_i = 1; tick();
    atn_i = 1; tick();
    chk("R9", "byte kept", data_o, 8'h33);
    chk("R9", "atn mid-handshake", ndac_o, 1);
    dav_i = 0; atn_i = 0; tick();
    chk("R9", "pending blocks ready", nrfd_o, 1);
    read_byte(); chk("R9", "ready after read", nrfd_o, 0);

    cur_req = "R11";
    listen_en_i = 0; tick();
    chk("R11", "idle nrfd", nrfd_o, 0); chk("R11", "idle ndac", ndac_o, 0);
    dio_i = 8'hC3; dav_i = 1; tick(3);
    chk("R11", "dav ignored", data_o, 8'h33);
    dav_i = 0; tick(2);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule